// File: doc/BRIEF.md
# Aging-Aware Adaptive Hold Logic

This block sits in front of a bypassing array multiplier that runs with variable latency. For every operand pair offered to the multiplier, it looks at the one operand that steers bypassing. For a column-bypassing array that is the multiplicand. For a row-bypassing array it is the multiplier operand. The block counts the zero bits of that operand. An operand with many zeros switches off many adder cells and settles within one clock. An operand with few zeros is given a second cycle, and the block withholds the input-register enable for that cycle.

Two threshold comparators judge the zero count. A lenient one is used while the silicon is fresh. A stricter one takes over once the circuit has aged. The output error-detecting registers of the multiplier report late-settling results back to the block. Each such report stalls the input registers for one extra cycle so that the faulty operation can be redone. The report is also counted in a window that spans a fixed number of accepted operations. If the count passes a limit inside one window, the block switches permanently to the strict comparator, and it stays there until reset.

Top module: `aging_hold_logic`

## Requirements
- R1: After a synchronous active-high reset, `inEnable` is 1, `agedMode` is 0 and `twoCycle` is 0 when no operand is offered.
- R2: An operand is accepted when `opValid` and `inEnable` are both 1. While `agedMode` is 0, an accepted operand with fewer than ZERO_LENIENT (default 3) zero bits raises `twoCycle` in that same cycle. One with ZERO_LENIENT or more zero bits leaves `twoCycle` at 0.
- R3: While `agedMode` is 1, the threshold used instead is ZERO_STRICT (default 5, larger than ZERO_LENIENT).
- R4: An accepted two-cycle operand drives `inEnable` to 0 for exactly the following cycle, and `inEnable` returns to 1 in the cycle after that.
- R5: `razorErr` high in a cycle adds one stall cycle, starting in the next cycle. If the same cycle also accepts a two-cycle operand, `inEnable` stays 0 for the next two cycles.
- R6: While `inEnable` is 0, `opValid` and `operand` have no effect: `twoCycle` stays 0 and the operand counts neither toward the window nor toward stalls.
- R7: `agedMode` rises in the cycle after the error report that brings the count within the current window above ERR_LIMIT (default 2).
- R8: The window closes on the cycle that accepts its WINDOW-th operand (default 16). At that point the error count clears, so reports split across two windows that never exceed ERR_LIMIT in either window leave `agedMode` at 0.
- R9: Once set, `agedMode` stays 1 through any number of further windows and is cleared only by reset.
- R10: Back-to-back accepted one-cycle operands with no error report keep `inEnable` at 1 in every cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| opValid | input | 1 | A new operand pair is offered this cycle |
| operand | input | WIDTH | Bypass-steering operand of the offered pair |
| razorErr | input | 1 | Late-result report from the output error-detecting registers |
| inEnable | output | 1 | Enable for the multiplier input registers (0 = hold) |
| twoCycle | output | 1 | Accepted operand needs two cycles |
| agedMode | output | 1 | Strict zero-count threshold in force |

## Verification
Two stall sources can meet in one cycle: a two-cycle judgment and an error report. The bench provokes this by offering an all-ones operand in the same cycle that `razorErr` is high. It then expects `inEnable` to stay low for two cycles instead of one. A second meeting point is the window closing in the same cycle that error reports fall just short of the limit. The bench fills a window that holds two reports. It adds two more reports after the window closes and expects no switch-over. The next report then triggers the switch.

// File: rtl/ahl_pkg.sv
package ahl_pkg;

  // Strobes from the control section to the judging datapath
  typedef struct packed {
    logic judgeEn;    // an operand is being accepted this cycle
    logic selStrict;  // pick the strict judging block
  } ahlStrobes_t;

  // Stall counter: a two-cycle stall plus an error stall never exceed 2
  localparam int unsigned HOLD_W = 2;

endpackage

// File: rtl/ahl_judge.sv
module ahl_judge
  import ahl_pkg::*;
#(
  parameter int unsigned WIDTH        = 8,
  parameter int unsigned ZERO_LENIENT = 3,
  parameter int unsigned ZERO_STRICT  = 5
) (
  input  logic [WIDTH-1:0] operand,
  input  ahlStrobes_t      strobes,
  output logic             needTwo
);

  localparam int unsigned CNT_W = $clog2(WIDTH + 1);
  localparam int unsigned NUM_JUDGE = 2;

  logic [CNT_W-1:0] zeroCount;
  logic [NUM_JUDGE-1:0] oneCycle;

  // Population count of the inverted operand bits
  always_comb begin
    zeroCount = '0;
    for (int i = 0; i < int'(WIDTH); i++) begin
      zeroCount = zeroCount + {{(CNT_W-1){1'b0}}, ~operand[i]};
    end
  end

  // Judging blocks: index 0 lenient, index 1 strict
  for (genvar g = 0; g < NUM_JUDGE; g++) begin : gJudge
    localparam int unsigned THR = (g == 0) ? ZERO_LENIENT : ZERO_STRICT;
    assign oneCycle[g] = (32'(zeroCount) >= THR);
  end

  // Selection between the judging blocks
  logic pickedOne;
  assign pickedOne = strobes.selStrict ? oneCycle[1] : oneCycle[0];
  assign needTwo   = strobes.judgeEn & ~pickedOne;

endmodule

// File: rtl/ahl_ctrl.sv
module ahl_ctrl
  import ahl_pkg::*;
#(
  parameter int unsigned WINDOW    = 16,
  parameter int unsigned ERR_LIMIT = 2
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        opValid,
  input  logic        razorErr,
  input  logic        needTwo,
  output ahlStrobes_t strobes,
  output logic        inEnable,
  output logic        twoCycle,
  output logic        agedMode
);

  localparam int unsigned WIN_W = (WINDOW > 1) ? $clog2(WINDOW) : 1;
  localparam int unsigned ERR_W = $clog2(ERR_LIMIT + 2);
  localparam logic [WIN_W-1:0] WIN_LAST = WIN_W'(WINDOW - 1);
  localparam logic [ERR_W:0]   ERR_SAT  = (ERR_W+1)'(ERR_LIMIT + 1);

  logic [HOLD_W-1:0] holdCnt, holdNext, holdDec;
  logic [WIN_W-1:0]  winCnt;
  logic [ERR_W-1:0]  errCnt;
  logic              agedQ;

  logic              accept, winEnd, overLimit;
  logic [ERR_W:0]    errSum;

  // Hold register drives the enable
  assign inEnable          = (holdCnt == '0);
  assign accept            = opValid & inEnable;
  assign strobes.judgeEn   = accept;
  assign strobes.selStrict = agedQ;
  assign twoCycle          = needTwo;
  assign agedMode          = agedQ;

  // Stall bookkeeping: decrement, then add new stall causes
  always_comb begin
    holdDec  = (holdCnt != '0) ? holdCnt - 1'b1 : '0;
    holdNext = holdDec + {{(HOLD_W-1){1'b0}}, needTwo}
                       + {{(HOLD_W-1){1'b0}}, razorErr};
  end

  // Aging indicator: error count over a window of accepted operations
  assign errSum    = {1'b0, errCnt} + {{ERR_W{1'b0}}, razorErr};
  assign overLimit = (errSum > (ERR_W+1)'(ERR_LIMIT));
  assign winEnd    = accept && (winCnt == WIN_LAST);

  always_ff @(posedge clk) begin
    if (rst) begin
      holdCnt <= '0;
      winCnt  <= '0;
      errCnt  <= '0;
      agedQ   <= 1'b0;
    end else begin
      holdCnt <= holdNext;
      if (overLimit) agedQ <= 1'b1;
      if (winEnd) begin
        winCnt <= '0;
        errCnt <= '0;
      end else begin
        if (accept) winCnt <= winCnt + 1'b1;
        errCnt <= overLimit ? ERR_SAT[ERR_W-1:0] : errSum[ERR_W-1:0];
      end
    end
  end

endmodule

// File: rtl/aging_hold_logic.sv
module aging_hold_logic
  import ahl_pkg::*;
#(
  parameter int unsigned WIDTH        = 8,
  parameter int unsigned ZERO_LENIENT = 3,
  parameter int unsigned ZERO_STRICT  = 5,
  parameter int unsigned WINDOW       = 16,
  parameter int unsigned ERR_LIMIT    = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             opValid,
  input  logic [WIDTH-1:0] operand,
  input  logic             razorErr,
  output logic             inEnable,
  output logic             twoCycle,
  output logic             agedMode
);

  ahlStrobes_t strobes;
  logic        needTwo;

  ahl_judge #(
    .WIDTH       (WIDTH),
    .ZERO_LENIENT(ZERO_LENIENT),
    .ZERO_STRICT (ZERO_STRICT)
  ) uJudge (
    .operand(operand),
    .strobes(strobes),
    .needTwo(needTwo)
  );

  ahl_ctrl #(
    .WINDOW   (WINDOW),
    .ERR_LIMIT(ERR_LIMIT)
  ) uCtrl (
    .clk     (clk),
    .rst     (rst),
    .opValid (opValid),
    .razorErr(razorErr),
    .needTwo (needTwo),
    .strobes (strobes),
    .inEnable(inEnable),
    .twoCycle(twoCycle),
    .agedMode(agedMode)
  );

endmodule

// File: rtl/ahl_checker.sv
module ahl_checker #(
  parameter int unsigned WIDTH        = 8,
  parameter int unsigned ZERO_LENIENT = 3,
  parameter int unsigned ZERO_STRICT  = 5
) (
  input logic             clk,
  input logic             rst,
  input logic             opValid,
  input logic [WIDTH-1:0] operand,
  input logic             razorErr,
  input logic             inEnable,
  input logic             twoCycle,
  input logic             agedMode
);

  assert_lenient_R2: assert property (@(posedge clk) disable iff (rst)
    (!agedMode && opValid && inEnable && ($countones(~operand) < ZERO_LENIENT)) |-> twoCycle);

  assert_strict_R3: assert property (@(posedge clk) disable iff (rst)
    (agedMode && opValid && inEnable && ($countones(~operand) >= ZERO_STRICT)) |-> !twoCycle);

  assert_stall_after_two_R4: assert property (@(posedge clk) disable iff (rst)
    twoCycle |=> !inEnable);

  assert_err_stall_R5: assert property (@(posedge clk) disable iff (rst)
    razorErr |=> !inEnable);

  assert_quiet_when_held_R6: assert property (@(posedge clk) disable iff (rst)
    !inEnable |-> !twoCycle);

  assert_aging_cause_R7: assert property (@(posedge clk) disable iff (rst)
    $rose(agedMode) |-> $past(razorErr));

  assert_aged_sticky_R9: assert property (@(posedge clk) disable iff (rst)
    agedMode |=> agedMode);

  assert_no_spurious_stall_R10: assert property (@(posedge clk) disable iff (rst)
    (inEnable && !twoCycle && !razorErr) |=> inEnable);

endmodule

bind aging_hold_logic ahl_checker #(
  .WIDTH       (WIDTH),
  .ZERO_LENIENT(ZERO_LENIENT),
  .ZERO_STRICT (ZERO_STRICT)
) uChk (
  .clk     (clk),
  .rst     (rst),
  .opValid (opValid),
  .operand (operand),
  .razorErr(razorErr),
  .inEnable(inEnable),
  .twoCycle(twoCycle),
  .agedMode(agedMode)
);

// File: tb/sim_aging_hold_logic.sv
`timescale 1ns/100ps
module sim_aging_hold_logic;

  localparam int WIDTH = 8;
  localparam int ZL    = 3;
  localparam int ZS    = 5;
  localparam int WIN   = 16;
  localparam int LIM   = 2;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic opValid = 1'b0;
  logic [WIDTH-1:0] operand = '0;
  logic razorErr = 1'b0;
  logic inEnable, twoCycle, agedMode;

  always #2 clk = ~clk;

  aging_hold_logic #(
    .WIDTH(WIDTH), .ZERO_LENIENT(ZL), .ZERO_STRICT(ZS),
    .WINDOW(WIN), .ERR_LIMIT(LIM)
  ) u0 (
    .clk(clk), .rst(rst), .opValid(opValid), .operand(operand),
    .razorErr(razorErr), .inEnable(inEnable), .twoCycle(twoCycle),
    .agedMode(agedMode)
  );

  typedef struct {
    logic  en;
    logic  two;
    logic  aged;
    string tag;
  } item_t;

  item_t q[$];
  int compared = 0;
  int mismatched = 0;
  bit done = 0;

  // Reference state derived from the requirements
  int mHold = 0, mWin = 0, mErr = 0;
  bit mAged = 0;

  task automatic doReset();
    @(negedge clk);
    rst = 1'b1; opValid = 1'b0; razorErr = 1'b0;
    repeat (2) @(negedge clk);
    rst = 1'b0;
    mHold = 0; mWin = 0; mErr = 0; mAged = 0;
  endtask

  task automatic step(input bit v, input logic [WIDTH-1:0] op, input bit e, input string tag);
    item_t it;
    int zc, holdN, errT;
    bit acc, two;
    @(negedge clk);
    opValid = v; operand = op; razorErr = e;
    zc = 0;
    for (int i = 0; i < WIDTH; i++) if (op[i] == 1'b0) zc++;
    acc = v && (mHold == 0);
    two = acc && (zc < (mAged ? ZS : ZL));
    it.en = (mHold == 0); it.two = two; it.aged = mAged; it.tag = tag;
    q.push_back(it);
    holdN = ((mHold > 0) ? mHold - 1 : 0) + int'(two) + int'(e);
    errT = mErr + int'(e);
    if (errT > LIM) mAged = 1;
    if (acc && mWin == WIN - 1) begin
      mWin = 0; mErr = 0;
    end else begin
      mWin += int'(acc);
      mErr = errT;
    end
    mHold = holdN;
  endtask

  // Monitor: pops expectations and compares them with the outputs
  initial begin
    forever begin
      @(negedge clk);
      #1;
      if (q.size() > 0) begin
        item_t it;
        it = q.pop_front();
        compared++;
        if (inEnable !== it.en || twoCycle !== it.two || agedMode !== it.aged) begin
          mismatched++;
          $display("FAIL %s: inEnable/twoCycle/agedMode got %b%b%b expected %b%b%b",
                   it.tag, inEnable, twoCycle, agedMode, it.en, it.two, it.aged);
        end
      end
    end
  end

  initial begin
    #(4 * 20000);
    if (!done) begin
      mismatched++;
      $display("FAIL watchdog: run did not finish, got hung expected done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  initial begin
    doReset();
    step(0, 8'h00, 0, "R1");
    // R2/R10: one-cycle operands back to back, boundary at exactly 3 zeros
    step(1, 8'h00, 0, "R10");
    step(1, 8'hF0, 0, "R10");
    step(1, 8'hF8, 0, "R2");
    // R2/R4/R6: two zeros -> two-cycle; offered operand during stall ignored
    step(1, 8'hFC, 0, "R2");
    step(1, 8'h00, 0, "R6");
    step(0, 8'h00, 0, "R4");
    // R5: error alone
    step(0, 8'h00, 1, "R5");
    step(0, 8'h00, 0, "R5");
    step(0, 8'h00, 0, "R5");
    // R5: two-cycle and error in the same cycle
    step(1, 8'hFF, 1, "R5");
    step(1, 8'h00, 0, "R5");
    step(1, 8'h00, 0, "R5");
    // R8: close the window holding two errors
    for (int k = 0; k < 11; k++) step(1, 8'h00, 0, "R8");
    step(0, 8'h00, 1, "R8");
    step(0, 8'h00, 0, "R8");
    step(0, 8'h00, 1, "R8");
    step(0, 8'h00, 0, "R8");
    step(0, 8'h00, 0, "R8");
    // R7: third error in this window flips to the strict criterion
    step(0, 8'h00, 1, "R7");
    step(0, 8'h00, 0, "R7");
    step(0, 8'h00, 0, "R7");
    // R3: four zeros now two-cycle, five zeros one-cycle
    step(1, 8'hF0, 0, "R3");
    step(0, 8'h00, 0, "R3");
    step(1, 8'hE0, 0, "R3");
    step(1, 8'h07, 0, "R3");
    // R9: aged flag survives further windows
    for (int k = 0; k < 20; k++) step(1, 8'h00, 0, "R9");
    doReset();
    step(0, 8'h00, 0, "R9");
    step(1, 8'hF0, 0, "R9");
    @(negedge clk);
    #2;
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

endmodule